// File: doc/BRIEF.md
# Coalescing Miss Request Tracker

This block sits below two upper-level caches and tracks the cache lines they are missing. An instruction-side port and a data-side port each present a line address on a valid/ready request channel. The tracker marks which sides wait on each line. A line that is already outstanding is not fetched a second time: the later request is folded into the existing entry. Each distinct line produces exactly one request on the downstream valid/ready channel, and these requests go out oldest entry first.

The downstream level may answer in any order. Each response carries its line address and a whole 64-byte line. The response is matched by address against entries that are issued but not yet filled, and the line is written into that entry in the same cycle. Every side that waits on the line then sees it on its own delivery channel. The two delivery channels progress independently. An entry returns to the free pool only once every side that waited on it has taken the line.

Back-pressure rules: a request port is held off with ready low only when the line needs a new entry and none is free. A delivery or downstream request, once valid, keeps its line and data unchanged until the receiver takes it. The response input has no ready: the tracker always takes a response in the cycle it is valid.

Top module: `miss_merge_tracker`

## Requirements
- R1: While reset is held and after it is released, both request ready outputs are 1 and the downstream request and both delivery valids are 0.
- R2: A request accepted at clock edge t for a line not outstanding makes dn_req_valid 1 with that line right after edge t.
- R3: A request for a line already held in an entry, from either side, produces no further downstream request, and that side still receives the line.
- R4: When both sides request the same new line in one cycle, a single downstream request is made and both sides receive the line.
- R5: When both sides request two different new lines in one cycle, two entries are taken and the instruction-side line is requested downstream first.
- R6: Downstream requests leave one per accepted cycle in allocation order, and a request not taken keeps valid high and its line unchanged.
- R7: Responses are matched by line address, whatever their order. A response whose line matches no issued, unfilled entry changes nothing at the outputs.
- R8: A response at edge t makes each waiting side's delivery valid right after edge t, with the line address and the 64-byte data. A delivery not taken holds its line and data, and taking it on one side does not remove it from the other side.
- R9: An entry is released only after every side waiting on it has accepted the line, and only then can a new line use its slot.
- R10: When all entries are in use, a request for a new line sees ready 0, while a request for a line already held sees ready 1.
- R11: With exactly one free entry and two different new lines requested in one cycle, the instruction side is accepted and the data side sees ready 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| i_req_valid | input | 1 | Instruction-side request valid |
| i_req_ready | output | 1 | Instruction-side request accepted |
| i_req_line | input | ADDR_W-6 | Instruction-side line address |
| d_req_valid | input | 1 | Data-side request valid |
| d_req_ready | output | 1 | Data-side request accepted |
| d_req_line | input | ADDR_W-6 | Data-side line address |
| dn_req_valid | output | 1 | Downstream fetch request valid |
| dn_req_ready | input | 1 | Downstream takes the request |
| dn_req_line | output | ADDR_W-6 | Line to fetch |
| dn_rsp_valid | input | 1 | Downstream response valid |
| dn_rsp_line | input | ADDR_W-6 | Line address of the response |
| dn_rsp_data | input | DATA_W | Line data |
| i_dlv_valid | output | 1 | Line ready for the instruction side |
| i_dlv_ready | input | 1 | Instruction side takes the line |
| i_dlv_line | output | ADDR_W-6 | Delivered line address |
| i_dlv_data | output | DATA_W | Delivered line data |
| d_dlv_valid | output | 1 | Line ready for the data side |
| d_dlv_ready | input | 1 | Data side takes the line |
| d_dlv_line | output | ADDR_W-6 | Delivered line address |
| d_dlv_data | output | DATA_W | Delivered line data |

## Verification
Request readiness is combinational, so the bench drives a request away from the edge and reads ready a moment later, before the edge that would accept it. A downstream request is due right after the edge that accepts the request. A delivery is due right after the edge that carries the response. The bench advances one edge at a time and samples two time units after each edge. Under back-pressure it holds ready low across an edge and samples again to confirm the same line is still offered.

// File: rtl/mt_pkg.sv
package mt_pkg;
  localparam int unsigned LINE_BYTES = 64;
  localparam int unsigned OFFS_W     = $clog2(LINE_BYTES);
  typedef enum logic {SIDE_I = 1'b0, SIDE_D = 1'b1} side_e;
endpackage

// File: rtl/mt_pick.sv
module mt_pick #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    any_o = |req_i;
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (req_i[k]) idx_o = IW'(k);
    end
  end
endmodule

// File: rtl/mt_match.sv
module mt_match #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 34,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  vld_i,
  input  logic [W-1:0]  lines_i [N],
  input  logic [W-1:0]  key_i,
  output logic          hit_o,
  output logic [IW-1:0] idx_o
);
  logic [N-1:0] eq;
  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = vld_i[g] && (lines_i[g] == key_i);
  end
  mt_pick #(.N(N), .IW(IW)) u_pick (.req_i(eq), .any_o(hit_o), .idx_o(idx_o));
endmodule

// File: rtl/mt_order_fifo.sv
module mt_order_fifo #(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push0_i,
  input  logic [IW-1:0] dat0_i,
  input  logic          push1_i,
  input  logic [IW-1:0] dat1_i,
  input  logic          pop_i,
  output logic [IW-1:0] head_o,
  output logic          nempty_o
);
  logic [IW-1:0] slot [N];
  logic [IW-1:0] wp, rp;
  logic [IW:0]   cnt;
  logic [IW-1:0] wp1;

  assign wp1      = wp + IW'(push0_i);
  assign head_o   = slot[rp];
  assign nempty_o = (cnt != '0);

  always_ff @(posedge clk) begin
    if (push0_i) slot[wp]  <= dat0_i;
    if (push1_i) slot[wp1] <= dat1_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + IW'(push0_i) + IW'(push1_i);
      rp  <= rp + IW'(pop_i);
      cnt <= cnt + (IW+1)'(push0_i) + (IW+1)'(push1_i) - (IW+1)'(pop_i);
    end
  end
endmodule

// File: rtl/miss_merge_tracker.sv
module miss_merge_tracker #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned ADDR_W  = 40,
  parameter int unsigned DATA_W  = mt_pkg::LINE_BYTES * 8
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              i_req_valid,
  output logic                              i_req_ready,
  input  logic [ADDR_W-mt_pkg::OFFS_W-1:0]  i_req_line,
  input  logic                              d_req_valid,
  output logic                              d_req_ready,
  input  logic [ADDR_W-mt_pkg::OFFS_W-1:0]  d_req_line,
  output logic                              dn_req_valid,
  input  logic                              dn_req_ready,
  output logic [ADDR_W-mt_pkg::OFFS_W-1:0]  dn_req_line,
  input  logic                              dn_rsp_valid,
  input  logic [ADDR_W-mt_pkg::OFFS_W-1:0]  dn_rsp_line,
  input  logic [DATA_W-1:0]                 dn_rsp_data,
  output logic                              i_dlv_valid,
  input  logic                              i_dlv_ready,
  output logic [ADDR_W-mt_pkg::OFFS_W-1:0]  i_dlv_line,
  output logic [DATA_W-1:0]                 i_dlv_data,
  output logic                              d_dlv_valid,
  input  logic                              d_dlv_ready,
  output logic [ADDR_W-mt_pkg::OFFS_W-1:0]  d_dlv_line,
  output logic [DATA_W-1:0]                 d_dlv_data
);
  localparam int unsigned LINE_W = ADDR_W - mt_pkg::OFFS_W;
  localparam int unsigned IW     = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

  // entry state
  logic [ENTRIES-1:0] e_vld, e_iss, e_fill, e_wi, e_wd;
  logic [LINE_W-1:0]  e_line [ENTRIES];
  logic [DATA_W-1:0]  e_data [ENTRIES];
  logic [ENTRIES-1:0] n_wi, n_wd;

  // address matching
  logic          hit_i, hit_d, hit_r;
  logic [IW-1:0] hidx_i, hidx_d, ridx;
  logic [ENTRIES-1:0] rsp_mask;
  assign rsp_mask = e_vld & e_iss & ~e_fill;

  mt_match #(.N(ENTRIES), .W(LINE_W), .IW(IW)) u_match_i (
    .vld_i(e_vld), .lines_i(e_line), .key_i(i_req_line), .hit_o(hit_i), .idx_o(hidx_i));
  mt_match #(.N(ENTRIES), .W(LINE_W), .IW(IW)) u_match_d (
    .vld_i(e_vld), .lines_i(e_line), .key_i(d_req_line), .hit_o(hit_d), .idx_o(hidx_d));
  mt_match #(.N(ENTRIES), .W(LINE_W), .IW(IW)) u_match_r (
    .vld_i(rsp_mask), .lines_i(e_line), .key_i(dn_rsp_line), .hit_o(hit_r), .idx_o(ridx));

  // free slot selection: first and second free entry
  logic          free0, free1;
  logic [IW-1:0] f0_idx, f1_idx;
  logic [ENTRIES-1:0] free_rest;
  assign free_rest = ~e_vld & ~({{(ENTRIES-1){1'b0}}, 1'b1} << f0_idx);

  mt_pick #(.N(ENTRIES), .IW(IW)) u_free0 (.req_i(~e_vld),   .any_o(free0), .idx_o(f0_idx));
  mt_pick #(.N(ENTRIES), .IW(IW)) u_free1 (.req_i(free_rest), .any_o(free1), .idx_o(f1_idx));

  // request acceptance
  logic          i_fire, d_fire, i_alloc, d_alloc, d_same;
  logic [IW-1:0] i_slot, d_slot;

  assign i_req_ready = hit_i || free0;
  assign i_fire      = i_req_valid && i_req_ready;
  assign i_alloc     = i_fire && !hit_i;
  assign d_same      = i_alloc && (d_req_line == i_req_line);
  assign d_req_ready = hit_d || d_same || (i_alloc ? free1 : free0);
  assign d_fire      = d_req_valid && d_req_ready;
  assign d_alloc     = d_fire && !hit_d && !d_same;
  assign i_slot      = hit_i ? hidx_i : f0_idx;
  assign d_slot      = hit_d  ? hidx_d :
                       d_same ? f0_idx :
                       i_alloc ? f1_idx : f0_idx;

  // downstream issue order
  logic          ord_ne, dn_fire;
  logic [IW-1:0] ord_head;

  mt_order_fifo #(.N(ENTRIES), .IW(IW)) u_order (
    .clk(clk), .rst_n(rst_n),
    .push0_i(i_alloc), .dat0_i(f0_idx),
    .push1_i(d_alloc), .dat1_i(d_slot),
    .pop_i(dn_fire), .head_o(ord_head), .nempty_o(ord_ne));

  assign dn_req_valid = ord_ne;
  assign dn_req_line  = e_line[ord_head];
  assign dn_fire      = dn_req_valid && dn_req_ready;

  // delivery selection, held while stalled
  logic          pi_any, pd_any, hi_v, hd_v, i_dfire, d_dfire;
  logic [IW-1:0] pi_idx, pd_idx, hi_idx, hd_idx, i_idx, d_idx;

  mt_pick #(.N(ENTRIES), .IW(IW)) u_pick_i (.req_i(e_vld & e_fill & e_wi), .any_o(pi_any), .idx_o(pi_idx));
  mt_pick #(.N(ENTRIES), .IW(IW)) u_pick_d (.req_i(e_vld & e_fill & e_wd), .any_o(pd_any), .idx_o(pd_idx));

  assign i_idx       = hi_v ? hi_idx : pi_idx;
  assign d_idx       = hd_v ? hd_idx : pd_idx;
  assign i_dlv_valid = hi_v || pi_any;
  assign d_dlv_valid = hd_v || pd_any;
  assign i_dlv_line  = e_line[i_idx];
  assign d_dlv_line  = e_line[d_idx];
  assign i_dlv_data  = e_data[i_idx];
  assign d_dlv_data  = e_data[d_idx];
  assign i_dfire     = i_dlv_valid && i_dlv_ready;
  assign d_dfire     = d_dlv_valid && d_dlv_ready;

  // waiting masks: delivery clears first, a new request sets after
  always_comb begin
    n_wi = e_wi;
    n_wd = e_wd;
    if (i_dfire) n_wi[i_idx]  = 1'b0;
    if (d_dfire) n_wd[d_idx]  = 1'b0;
    if (i_fire)  n_wi[i_slot] = 1'b1;
    if (d_fire)  n_wd[d_slot] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_vld  <= '0;
      e_iss  <= '0;
      e_fill <= '0;
      e_wi   <= '0;
      e_wd   <= '0;
      hi_v   <= 1'b0;
      hd_v   <= 1'b0;
      hi_idx <= '0;
      hd_idx <= '0;
    end else begin
      e_wi   <= n_wi;
      e_wd   <= n_wd;
      hi_v   <= i_dlv_valid && !i_dlv_ready;
      hd_v   <= d_dlv_valid && !d_dlv_ready;
      hi_idx <= i_idx;
      hd_idx <= d_idx;
      for (int k = 0; k < ENTRIES; k++) begin
        if ((i_alloc && f0_idx == IW'(k)) || (d_alloc && d_slot == IW'(k))) begin
          e_vld[k]  <= 1'b1;
          e_iss[k]  <= 1'b0;
          e_fill[k] <= 1'b0;
        end else begin
          if (e_vld[k] && !n_wi[k] && !n_wd[k]) e_vld[k] <= 1'b0;
          if (dn_fire && ord_head == IW'(k))     e_iss[k] <= 1'b1;
          if (dn_rsp_valid && hit_r && ridx == IW'(k)) e_fill[k] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < ENTRIES; k++) begin
      if (i_alloc && f0_idx == IW'(k))      e_line[k] <= i_req_line;
      else if (d_alloc && d_slot == IW'(k)) e_line[k] <= d_req_line;
      if (dn_rsp_valid && hit_r && ridx == IW'(k)) e_data[k] <= dn_rsp_data;
    end
  end
endmodule

// File: rtl/miss_merge_tracker_chk.sv
module miss_merge_tracker_chk #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned LINE_W  = 34,
  parameter int unsigned DATA_W  = 512
) (
  input logic               clk,
  input logic               rst_n,
  input logic               i_req_valid,
  input logic               i_req_ready,
  input logic               d_req_valid,
  input logic               d_req_ready,
  input logic               dn_req_valid,
  input logic               dn_req_ready,
  input logic [LINE_W-1:0]  dn_req_line,
  input logic               i_dlv_valid,
  input logic               i_dlv_ready,
  input logic [LINE_W-1:0]  i_dlv_line,
  input logic [DATA_W-1:0]  i_dlv_data,
  input logic               d_dlv_valid,
  input logic               d_dlv_ready,
  input logic [LINE_W-1:0]  d_dlv_line,
  input logic [DATA_W-1:0]  d_dlv_data,
  input logic [ENTRIES-1:0] e_vld
);
  AST_DN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_line)); // R6
  AST_I_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    i_dlv_valid && !i_dlv_ready |=> i_dlv_valid && $stable(i_dlv_line) && $stable(i_dlv_data)); // R8
  AST_D_DLV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    d_dlv_valid && !d_dlv_ready |=> d_dlv_valid && $stable(d_dlv_line) && $stable(d_dlv_data)); // R8
  AST_I_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    i_req_valid && !i_req_ready |-> (&e_vld)); // R10
  AST_D_STALL_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    d_req_valid && !d_req_ready |-> ($countones(e_vld) >= ENTRIES - 1)); // R11
  AST_IDLE_RESET: assert property (@(posedge clk)
    !rst_n |-> !dn_req_valid && !i_dlv_valid && !d_dlv_valid); // R1
endmodule

bind miss_merge_tracker miss_merge_tracker_chk #(
  .ENTRIES(ENTRIES), .LINE_W(LINE_W), .DATA_W(DATA_W)
) u_chk (.*);

// File: tb/test_miss_merge_tracker.sv
module test_miss_merge_tracker;
  localparam int unsigned LW = 34;
  localparam int unsigned DW = 512;

  logic clk = 1'b0, rst_n = 1'b0;
  logic i_req_valid = 0, d_req_valid = 0, dn_req_ready = 0, dn_rsp_valid = 0;
  logic i_dlv_ready = 0, d_dlv_ready = 0;
  logic [LW-1:0] i_req_line = '0, d_req_line = '0, dn_rsp_line = '0;
  logic [DW-1:0] dn_rsp_data = '0;
  logic i_req_ready, d_req_ready, dn_req_valid, i_dlv_valid, d_dlv_valid;
  logic [LW-1:0] dn_req_line, i_dlv_line, d_dlv_line;
  logic [DW-1:0] i_dlv_data, d_dlv_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  miss_merge_tracker i_miss_merge_tracker (
    .clk(clk), .rst_n(rst_n),
    .i_req_valid(i_req_valid), .i_req_ready(i_req_ready), .i_req_line(i_req_line),
    .d_req_valid(d_req_valid), .d_req_ready(d_req_ready), .d_req_line(d_req_line),
    .dn_req_valid(dn_req_valid), .dn_req_ready(dn_req_ready), .dn_req_line(dn_req_line),
    .dn_rsp_valid(dn_rsp_valid), .dn_rsp_line(dn_rsp_line), .dn_rsp_data(dn_rsp_data),
    .i_dlv_valid(i_dlv_valid), .i_dlv_ready(i_dlv_ready), .i_dlv_line(i_dlv_line), .i_dlv_data(i_dlv_data),
    .d_dlv_valid(d_dlv_valid), .d_dlv_ready(d_dlv_ready), .d_dlv_line(d_dlv_line), .d_dlv_data(d_dlv_data));

  function automatic logic [DW-1:0] mkdata(input logic [LW-1:0] ln);
    return {16{ln[31:0] ^ 32'hA5A5_0000}};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic respond(input logic [LW-1:0] ln);
    dn_rsp_valid = 1; dn_rsp_line = ln; dn_rsp_data = mkdata(ln);
    step();
    dn_rsp_valid = 0;
  endtask

  task automatic chk_dlv_i(input logic [LW-1:0] ln, input string req);
    chk(i_dlv_valid && i_dlv_line == ln, req, {i_dlv_valid, 30'd0, i_dlv_line}, {1'b1, 30'd0, ln});
    chk(i_dlv_data == mkdata(ln), req, i_dlv_data[63:0], mkdata(ln)[63:0]);
  endtask

  task automatic chk_dlv_d(input logic [LW-1:0] ln, input string req);
    chk(d_dlv_valid && d_dlv_line == ln, req, {d_dlv_valid, 30'd0, d_dlv_line}, {1'b1, 30'd0, ln});
    chk(d_dlv_data == mkdata(ln), req, d_dlv_data[63:0], mkdata(ln)[63:0]);
  endtask

  task automatic t_reset();
    #2;
    chk(i_req_ready && d_req_ready, "R1 ready in reset", {i_req_ready, d_req_ready}, 2'b11);
    chk(!dn_req_valid && !i_dlv_valid && !d_dlv_valid, "R1 idle in reset",
        {dn_req_valid, i_dlv_valid, d_dlv_valid}, 0);
    step(); rst_n = 1; step();
    chk(i_req_ready && d_req_ready && !dn_req_valid && !i_dlv_valid && !d_dlv_valid,
        "R1 idle after reset", {i_req_ready, d_req_ready, dn_req_valid, i_dlv_valid, d_dlv_valid}, 5'b11000);
  endtask

  task automatic t_single();
    i_req_valid = 1; i_req_line = 34'h10;
    step(); i_req_valid = 0;
    chk(dn_req_valid && dn_req_line == 34'h10, "R2 downstream request", dn_req_line, 34'h10);
    step();
    chk(dn_req_valid && dn_req_line == 34'h10, "R6 request held", dn_req_line, 34'h10);
    dn_req_ready = 1; step(); dn_req_ready = 0;
    chk(!dn_req_valid, "R6 one request per line", dn_req_valid, 0);
    respond(34'h10);
    chk_dlv_i(34'h10, "R8 delivery after response");
    chk(!d_dlv_valid, "R8 other side idle", d_dlv_valid, 0);
    step();
    chk_dlv_i(34'h10, "R8 delivery held");
    i_dlv_ready = 1; step(); i_dlv_ready = 0;
    chk(!i_dlv_valid, "R8 delivery taken", i_dlv_valid, 0);
  endtask

  task automatic t_merge();
    i_req_valid = 1; i_req_line = 34'h20;
    step(); i_req_valid = 0;
    dn_req_ready = 1; step(); dn_req_ready = 0;
    d_req_valid = 1; d_req_line = 34'h20; #1;
    chk(d_req_ready, "R3 merge accepted", d_req_ready, 1);
    step(); d_req_valid = 0;
    chk(!dn_req_valid, "R3 no second request", dn_req_valid, 0);
    respond(34'h20);
    chk_dlv_i(34'h20, "R3 I side gets line");
    chk_dlv_d(34'h20, "R3 D side gets line");
    d_dlv_ready = 1; step(); d_dlv_ready = 0;
    chk(!d_dlv_valid, "R8 D taken", d_dlv_valid, 0);
    chk_dlv_i(34'h20, "R8 I independent of D");
    i_dlv_ready = 1; step(); i_dlv_ready = 0;
    chk(!i_dlv_valid, "R9 entry drained", i_dlv_valid, 0);
  endtask

  task automatic t_same_cycle();
    i_req_valid = 1; i_req_line = 34'h30;
    d_req_valid = 1; d_req_line = 34'h30; #1;
    chk(i_req_ready && d_req_ready, "R4 both accepted", {i_req_ready, d_req_ready}, 2'b11);
    step(); i_req_valid = 0; d_req_valid = 0;
    chk(dn_req_valid && dn_req_line == 34'h30, "R4 single request", dn_req_line, 34'h30);
    dn_req_ready = 1; step(); dn_req_ready = 0;
    chk(!dn_req_valid, "R4 no duplicate", dn_req_valid, 0);
    respond(34'h30);
    chk_dlv_i(34'h30, "R4 I delivery");
    chk_dlv_d(34'h30, "R4 D delivery");
    i_dlv_ready = 1; d_dlv_ready = 1; step(); i_dlv_ready = 0; d_dlv_ready = 0;
  endtask

  task automatic t_two_lines_ooo();
    i_req_valid = 1; i_req_line = 34'h40;
    d_req_valid = 1; d_req_line = 34'h50;
    step(); i_req_valid = 0; d_req_valid = 0;
    chk(dn_req_valid && dn_req_line == 34'h40, "R5 I line first", dn_req_line, 34'h40);
    dn_req_ready = 1; step();
    chk(dn_req_valid && dn_req_line == 34'h50, "R5 D line second", dn_req_line, 34'h50);
    step(); dn_req_ready = 0;
    chk(!dn_req_valid, "R5 two requests only", dn_req_valid, 0);
    respond(34'h99);
    chk(!i_dlv_valid && !d_dlv_valid, "R7 unknown response ignored", {i_dlv_valid, d_dlv_valid}, 0);
    respond(34'h50);
    chk_dlv_d(34'h50, "R7 out of order match");
    chk(!i_dlv_valid, "R7 I not yet served", i_dlv_valid, 0);
    respond(34'h40);
    chk_dlv_i(34'h40, "R7 second response");
    i_dlv_ready = 1; d_dlv_ready = 1; step(); i_dlv_ready = 0; d_dlv_ready = 0;
  endtask

  task automatic t_full();
    for (int k = 0; k < 8; k++) begin
      i_req_valid = 1; i_req_line = 34'h100 + LW'(k);
      step();
    end
    i_req_valid = 0;
    i_req_valid = 1; i_req_line = 34'h200;
    d_req_valid = 1; d_req_line = 34'h103; #1;
    chk(!i_req_ready, "R10 new line stalls when full", i_req_ready, 0);
    chk(d_req_ready, "R10 matching line accepted when full", d_req_ready, 1);
    step(); i_req_valid = 0; d_req_valid = 0;
    dn_req_ready = 1;
    for (int k = 0; k < 8; k++) begin
      chk(dn_req_valid && dn_req_line == 34'h100 + LW'(k), "R6 oldest first", dn_req_line, 34'h100 + k);
      step();
    end
    dn_req_ready = 0;
    chk(!dn_req_valid, "R3 merged line not refetched", dn_req_valid, 0);
    respond(34'h103);
    chk_dlv_i(34'h103, "R9 I gets shared line");
    chk_dlv_d(34'h103, "R9 D gets shared line");
    i_dlv_ready = 1; step(); i_dlv_ready = 0;
    i_req_valid = 1; i_req_line = 34'h200; #1;
    chk(!i_req_ready, "R9 entry kept for D", i_req_ready, 0);
    i_req_valid = 0;
    d_dlv_ready = 1; step(); d_dlv_ready = 0;
    i_req_valid = 1; i_req_line = 34'h300;
    d_req_valid = 1; d_req_line = 34'h301; #1;
    chk(i_req_ready, "R11 I wins last entry", i_req_ready, 1);
    chk(!d_req_ready, "R11 D stalls", d_req_ready, 0);
    i_req_valid = 0; d_req_valid = 0;
    for (int k = 0; k < 8; k++) begin
      if (k != 3) respond(34'h100 + LW'(k));
    end
    i_dlv_ready = 1;
    repeat (10) step();
    i_dlv_ready = 0;
    chk(i_req_ready && d_req_ready && !i_dlv_valid && !dn_req_valid, "R9 all entries released",
        {i_req_ready, d_req_ready, i_dlv_valid, dn_req_valid}, 4'b1100);
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    t_reset();
    t_single();
    t_merge();
    t_same_cycle();
    t_two_lines_ooo();
    t_full();
    done = 1;
    report();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog (all R): actual hung expected finished");
      report();
    end
  end
endmodule